// File: doc/BRIEF.md
# Split-Cycle Atomic Commit Pipeline

This block performs the read-modify-write of an atomic memory operation in the last-level cache bank. It spreads the work over two clock cycles. In the read cycle the block takes the line read from the cache array, the word index of the target word, the operand, the opcode and the width select. In that same cycle it picks out the target word and returns it as the response, so the response comes no later than with a single-cycle commit. It also latches the aligned old value and the operand into a compute register.

One cycle later the arithmetic unit forms the new value. The new value is shifted back to its position in the line and merged into a writeback register, together with a byte-enable mask. A cache queue further down drains this register.

When two atomics on the same line arrive back to back, the second one is held for exactly one cycle by a chain stall, and it gives no response during that cycle. On the following cycle the first result sits in the writeback register, and its bytes are forwarded over the stale array data. Traffic that is not atomic passes through without touching any of the block's outputs.

Top module: `amo_commit_pipe`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rsp_valid`, `chain_stall`, `commit_busy` and `wb_valid` are all 0.
- R2: An accepted atomic raises `rsp_valid` in the same cycle it is presented. `rsp_data` holds the old value of word `req_widx`, which occupies line bits `[req_widx*WORD_W +: WORD_W]`.
- R3: The `req_op` codes are 0 swap, 1 add, 2 and, 3 or, 4 xor, 5 signed min, 6 signed max, 7 unsigned min and 8 unsigned max. The written value is the result of that operation on the old value and `req_operand`.
- R4: When the datapath is wider than 32 bits, `req_dw`=1 selects a full-width operation. `req_dw`=0 selects a 32-bit operation: it uses only the low 32 bits of both operands, the old value and the result are sign-extended, and only the low 4 bytes of the word are enabled for writeback.
- R5: One cycle after a request is accepted, `wb_valid` pulses for one cycle. At that point `wb_line` is the request line, the new value sits at the word's position in `wb_data`, and `wb_be` has bit b set for each written byte b of the line.
- R6: An atomic on the same line as the operation in the compute stage raises `chain_stall` for one cycle, and `rsp_valid` stays 0 during that cycle.
- R7: In the cycle after a chain stall, the old value is taken from the writeback register's bytes in place of the array data. The writeback register accumulates data and byte enables across consecutive results for the same line.
- R8: Back-to-back atomics on different lines never stall. Their writeback pulses come in consecutive cycles, and the second one carries only its own bytes.
- R9: A request with `req_is_amo`=0 never raises `chain_stall`, `rsp_valid`, `commit_busy` or `wb_valid`.
- R10: `commit_busy` is 1 exactly in the cycle after an atomic is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present in the read stage |
| req_is_amo | input | 1 | The request is an atomic |
| req_line | input | ADDR_W | Line address of the request |
| req_widx | input | WIDX_W | Word index within the line |
| req_op | input | 4 | Operation code |
| req_dw | input | 1 | 1 = full-width operation, 0 = 32-bit operation |
| req_operand | input | DATA_W | Operand |
| rd_line | input | LINE_W | Line read from the cache array |
| rsp_valid | output | 1 | Response (old value) valid |
| rsp_data | output | DATA_W | Old value |
| chain_stall | output | 1 | Hold the request one cycle |
| commit_busy | output | 1 | Compute stage occupied |
| wb_valid | output | 1 | Writeback register updated this cycle |
| wb_line | output | ADDR_W | Line held in the writeback register |
| wb_data | output | LINE_W | Line data for writeback |
| wb_byte_en | output | LINE_W/8 | Byte enables for writeback |

## Verification
The assertions check four things on every cycle. A stall appears only for an atomic request. A stalled request never responds. No same-line request enters the compute stage while the stage is occupied. Each busy cycle is preceded by a response and followed by a writeback pulse.

Only the bench scenarios can show that the values are right. These cover the result of every opcode and the sign handling of 32-bit operations, and they check forwarded old values against a stale array. They also check the accumulated byte enables across a chain and the fresh mask after a change of line.

// File: rtl/amo_pipe_pkg.sv
package amo_pipe_pkg;

    typedef enum logic [3:0] {
        AOP_SWAP = 4'd0,
        AOP_ADD  = 4'd1,
        AOP_AND  = 4'd2,
        AOP_OR   = 4'd3,
        AOP_XOR  = 4'd4,
        AOP_MIN  = 4'd5,
        AOP_MAX  = 4'd6,
        AOP_MINU = 4'd7,
        AOP_MAXU = 4'd8
    } amo_op_e;

endpackage

// File: rtl/amo_slot_read.sv
// Read-stage word extraction: merges forwarded writeback bytes over the
// array line, selects the target word and sign-extends 32-bit operations.
module amo_slot_read #(
    parameter int LINE_W = 256,
    parameter int WORD_W = 64,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 26,
    parameter int WIDX_W = 2
) (
    input  logic [LINE_W-1:0]   rd_line,
    input  logic [ADDR_W-1:0]   req_line,
    input  logic [WIDX_W-1:0]   req_widx,
    input  logic                req_dw,
    input  logic                fwd_vld,
    input  logic [ADDR_W-1:0]   fwd_line,
    input  logic [LINE_W-1:0]   fwd_data,
    input  logic [LINE_W/8-1:0] fwd_be,
    output logic [DATA_W-1:0]   old_val
);
    localparam int LINE_B = LINE_W / 8;
    localparam int WSH    = $clog2(WORD_W);
    localparam bit HAS_DW = (DATA_W > 32);

    logic                     fwd_hit;
    logic [LINE_W-1:0]        merged;
    logic [LINE_W-1:0]        shifted;
    logic [WIDX_W+WSH-1:0]    shamt;
    logic [DATA_W-1:0]        slot;

    assign fwd_hit = fwd_vld && (fwd_line == req_line);

    for (genvar b = 0; b < LINE_B; b++) begin : g_byte
        assign merged[b*8 +: 8] = (fwd_hit && fwd_be[b]) ? fwd_data[b*8 +: 8]
                                                         : rd_line[b*8 +: 8];
    end

    assign shamt   = {req_widx, {WSH{1'b0}}};
    assign shifted = merged >> shamt;
    assign slot    = shifted[DATA_W-1:0];

    if (HAS_DW) begin : g_dw
        assign old_val = req_dw ? slot : DATA_W'($signed(slot[31:0]));
    end else begin : g_w
        logic unused_dw;
        assign unused_dw = req_dw;
        assign old_val   = slot;
    end

endmodule

// File: rtl/amo_alu.sv
// Compute-stage arithmetic for atomic operations.
module amo_alu
    import amo_pipe_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_op_e             op,
    input  logic                dw,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   res
);
    localparam bit HAS_DW = (DATA_W > 32);

    logic              narrow;
    logic [DATA_W-1:0] b_e;
    logic [DATA_W-1:0] r;
    logic              lt_s;
    logic              lt_u;

    if (HAS_DW) begin : g_dw
        assign narrow = ~dw;
    end else begin : g_w
        logic unused_dw;
        assign unused_dw = dw;
        assign narrow    = 1'b1;
    end

    always_comb begin
        b_e  = narrow ? DATA_W'($signed(b[31:0])) : b;
        lt_s = $signed(a) < $signed(b_e);
        lt_u = a < b_e;
        unique case (op)
            AOP_SWAP: r = b_e;
            AOP_ADD:  r = a + b_e;
            AOP_AND:  r = a & b_e;
            AOP_OR:   r = a | b_e;
            AOP_XOR:  r = a ^ b_e;
            AOP_MIN:  r = lt_s ? a : b_e;
            AOP_MAX:  r = lt_s ? b_e : a;
            AOP_MINU: r = lt_u ? a : b_e;
            AOP_MAXU: r = lt_u ? b_e : a;
            default:  r = a;
        endcase
        res = narrow ? DATA_W'($signed(r[31:0])) : r;
    end

endmodule

// File: rtl/amo_wb_reg.sv
// Writeback register: places the new value back at its line position and
// accumulates bytes while successive results target the same line.
module amo_wb_reg #(
    parameter int LINE_W = 256,
    parameter int WORD_W = 64,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 26,
    parameter int WIDX_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_vld,
    input  logic [ADDR_W-1:0]   upd_line,
    input  logic [WIDX_W-1:0]   upd_widx,
    input  logic                upd_dw,
    input  logic [DATA_W-1:0]   upd_val,
    output logic                wb_valid,
    output logic [ADDR_W-1:0]   wb_line,
    output logic [LINE_W-1:0]   wb_data,
    output logic [LINE_W/8-1:0] wb_be
);
    localparam int LINE_B = LINE_W / 8;
    localparam int WORD_B = WORD_W / 8;
    localparam int DATA_B = DATA_W / 8;
    localparam int WSH    = $clog2(WORD_W);
    localparam int BSH    = $clog2(WORD_B);
    localparam bit HAS_DW = (DATA_W > 32);

    typedef struct packed {
        logic              vld;
        logic              have;
        logic [ADDR_W-1:0] line;
        logic [LINE_W-1:0] data;
        logic [LINE_B-1:0] be;
    } wb_t;

    wb_t wb_d, wb_q;

    logic              same;
    logic              full_w;
    logic [LINE_W-1:0] val_line;
    logic [LINE_B-1:0] new_be;
    logic [LINE_W-1:0] new_mask;
    logic [LINE_W-1:0] base_data;
    logic [LINE_B-1:0] base_be;

    if (HAS_DW) begin : g_dw
        assign full_w = upd_dw;
    end else begin : g_w
        logic unused_dw;
        assign unused_dw = upd_dw;
        assign full_w    = 1'b1;
    end

    assign val_line = LINE_W'(upd_val) << {upd_widx, {WSH{1'b0}}};
    assign new_be   = (full_w ? LINE_B'({DATA_B{1'b1}}) : LINE_B'(4'hF))
                      << {upd_widx, {BSH{1'b0}}};

    for (genvar b = 0; b < LINE_B; b++) begin : g_mask
        assign new_mask[b*8 +: 8] = {8{new_be[b]}};
    end

    assign same      = wb_q.have && (wb_q.line == upd_line);
    assign base_data = same ? wb_q.data : '0;
    assign base_be   = same ? wb_q.be   : '0;

    always_comb begin
        wb_d     = wb_q;
        wb_d.vld = 1'b0;
        if (upd_vld) begin
            wb_d.vld  = 1'b1;
            wb_d.have = 1'b1;
            wb_d.line = upd_line;
            wb_d.data = (base_data & ~new_mask) | (val_line & new_mask);
            wb_d.be   = base_be | new_be;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    assign wb_valid = wb_q.vld;
    assign wb_line  = wb_q.line;
    assign wb_data  = wb_q.data;
    assign wb_be    = wb_q.be;

    // R5
    wb_be_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_be != '0));

endmodule

// File: rtl/amo_commit_pipe.sv
// Two-stage atomic commit: read/respond stage, then compute/writeback stage.
module amo_commit_pipe
    import amo_pipe_pkg::*;
#(
    parameter int LINE_W = 256,
    parameter int WORD_W = 64,
    parameter int ADDR_W = 26,
    localparam int DATA_W = (WORD_W > 64) ? 64 : WORD_W,
    localparam int WIDX_W = (LINE_W / WORD_W > 1) ? $clog2(LINE_W / WORD_W) : 1,
    localparam int LINE_B = LINE_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_amo,
    input  logic [ADDR_W-1:0] req_line,
    input  logic [WIDX_W-1:0] req_widx,
    input  logic [3:0]        req_op,
    input  logic              req_dw,
    input  logic [DATA_W-1:0] req_operand,
    input  logic [LINE_W-1:0] rd_line,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              chain_stall,
    output logic              commit_busy,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_line,
    output logic [LINE_W-1:0] wb_data,
    output logic [LINE_B-1:0] wb_byte_en
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] line;
        logic [WIDX_W-1:0] widx;
        logic              dw;
        amo_op_e           op;
        logic [DATA_W-1:0] old;
        logic [DATA_W-1:0] opnd;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    logic              amo_req;
    logic              accept;
    logic [DATA_W-1:0] old_val;
    logic [DATA_W-1:0] new_val;

    amo_slot_read #(
        .LINE_W(LINE_W), .WORD_W(WORD_W), .DATA_W(DATA_W),
        .ADDR_W(ADDR_W), .WIDX_W(WIDX_W)
    ) u_read (
        .rd_line  (rd_line),
        .req_line (req_line),
        .req_widx (req_widx),
        .req_dw   (req_dw),
        .fwd_vld  (wb_valid),
        .fwd_line (wb_line),
        .fwd_data (wb_data),
        .fwd_be   (wb_byte_en),
        .old_val  (old_val)
    );

    always_comb begin
        amo_req     = req_valid && req_is_amo;
        chain_stall = amo_req && cmp_q.vld && (cmp_q.line == req_line);
        accept      = amo_req && !chain_stall;

        cmp_d      = cmp_q;
        cmp_d.vld  = accept;
        if (accept) begin
            cmp_d.line = req_line;
            cmp_d.widx = req_widx;
            cmp_d.dw   = req_dw;
            cmp_d.op   = amo_op_e'(req_op);
            cmp_d.old  = old_val;
            cmp_d.opnd = req_operand;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end

    assign rsp_valid   = accept;
    assign rsp_data    = old_val;
    assign commit_busy = cmp_q.vld;

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (cmp_q.op),
        .dw  (cmp_q.dw),
        .a   (cmp_q.old),
        .b   (cmp_q.opnd),
        .res (new_val)
    );

    amo_wb_reg #(
        .LINE_W(LINE_W), .WORD_W(WORD_W), .DATA_W(DATA_W),
        .ADDR_W(ADDR_W), .WIDX_W(WIDX_W)
    ) u_wb (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_vld  (cmp_q.vld),
        .upd_line (cmp_q.line),
        .upd_widx (cmp_q.widx),
        .upd_dw   (cmp_q.dw),
        .upd_val  (new_val),
        .wb_valid (wb_valid),
        .wb_line  (wb_line),
        .wb_data  (wb_data),
        .wb_be    (wb_byte_en)
    );

    // R6 R9
    stall_amo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_stall |-> (req_valid && req_is_amo));

    // R6
    stall_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_stall |-> !rsp_valid);

    // R6
    overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_busy && rsp_valid) |-> (req_line != cmp_q.line));

    // R5
    wb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_busy |=> wb_valid);

    // R10
    busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_busy |-> $past(rsp_valid));

endmodule

// File: tb/amo_commit_pipe_tb.sv
module amo_commit_pipe_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 256;
    localparam int WW = 64;
    localparam int AW = 26;
    localparam int LB = LW / 8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          req_valid = 0, req_is_amo = 0, req_dw = 0;
    logic [AW-1:0] req_line = '0;
    logic [1:0]    req_widx = '0;
    logic [3:0]    req_op = '0;
    logic [63:0]   req_operand = '0;
    logic [LW-1:0] rd_line = '0;
    logic          rsp_valid, chain_stall, commit_busy, wb_valid;
    logic [63:0]   rsp_data;
    logic [AW-1:0] wb_line;
    logic [LW-1:0] wb_data;
    logic [LB-1:0] wb_byte_en;

    int n_chk = 0, n_fail = 0;
    int next_line = 16;

    always #(CLK_PERIOD/2) clk = ~clk;

    amo_commit_pipe #(.LINE_W(LW), .WORD_W(WW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_amo(req_is_amo),
        .req_line(req_line), .req_widx(req_widx), .req_op(req_op), .req_dw(req_dw),
        .req_operand(req_operand), .rd_line(rd_line), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .chain_stall(chain_stall), .commit_busy(commit_busy),
        .wb_valid(wb_valid), .wb_line(wb_line), .wb_data(wb_data), .wb_byte_en(wb_byte_en)
    );

    task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] sx32(input logic [63:0] x);
        return {{32{x[31]}}, x[31:0]};
    endfunction

    function automatic logic [63:0] ref_op(input logic [3:0] op, input logic dw,
                                           input logic [63:0] a, input logic [63:0] b);
        logic [63:0] aa, bb, r;
        aa = dw ? a : sx32(a);
        bb = dw ? b : sx32(b);
        case (op)
            4'd0: r = bb;
            4'd1: r = aa + bb;
            4'd2: r = aa & bb;
            4'd3: r = aa | bb;
            4'd4: r = aa ^ bb;
            4'd5: r = ($signed(aa) < $signed(bb)) ? aa : bb;
            4'd6: r = ($signed(aa) > $signed(bb)) ? aa : bb;
            4'd7: r = (aa < bb) ? aa : bb;
            4'd8: r = (aa > bb) ? aa : bb;
            default: r = aa;
        endcase
        return dw ? r : sx32(r);
    endfunction

    function automatic logic [63:0] wslot(input logic [LW-1:0] l, input int i);
        return l[i*64 +: 64];
    endfunction

    function automatic logic [LB-1:0] exp_be(input int i, input logic dw);
        return (dw ? LB'(8'hFF) : LB'(8'h0F)) << (i*8);
    endfunction

    task automatic drive(input logic [AW-1:0] ln, input int i, input logic [3:0] op,
                         input logic dw, input logic [63:0] opnd, input logic [LW-1:0] rl);
        req_valid = 1; req_is_amo = 1; req_line = ln; req_widx = 2'(i);
        req_op = op; req_dw = dw; req_operand = opnd; rd_line = rl;
    endtask

    task automatic idle();
        req_valid = 0; req_is_amo = 0;
    endtask

    // single atomic: response, busy, writeback
    task automatic t_single(input string tag, input int i, input logic [3:0] op,
                            input logic dw, input logic [63:0] a, input logic [63:0] opnd);
        logic [LW-1:0] rl;
        logic [AW-1:0] ln;
        logic [63:0]   res, w;
        ln = AW'(next_line); next_line++;
        rl = {4{64'h5A5A_0F0F_C3C3_9696}};
        rl[i*64 +: 64] = a;
        res = ref_op(op, dw, a, opnd);
        @(negedge clk); drive(ln, i, op, dw, opnd, rl); #1;
        chk({"R2 rsp_valid ", tag}, LW'(rsp_valid), LW'(1));
        chk({"R2 rsp_data ", tag}, LW'(rsp_data), LW'(dw ? a : sx32(a)));
        @(negedge clk); idle(); #1;
        chk({"R10 busy ", tag}, LW'(commit_busy), LW'(1));
        @(negedge clk); #1;
        chk({"R5 wb_valid ", tag}, LW'(wb_valid), LW'(1));
        chk({"R5 wb_line ", tag}, LW'(wb_line), LW'(ln));
        w = wslot(wb_data, i);
        if (dw) chk({"R3 value ", tag}, LW'(w), LW'(res));
        else    chk({"R4 value ", tag}, LW'(w[31:0]), LW'(res[31:0]));
        chk({dw ? "R5 be " : "R4 be ", tag}, LW'(wb_byte_en), LW'(exp_be(i, dw)));
        chk({"R10 busy clear ", tag}, LW'(commit_busy), LW'(0));
    endtask

    task automatic t_reset();
        #1;
        chk("R1 rsp_valid", LW'(rsp_valid), LW'(0));
        chk("R1 chain_stall", LW'(chain_stall), LW'(0));
        @(negedge clk); rst_n = 1; #1;
        chk("R1 commit_busy", LW'(commit_busy), LW'(0));
        chk("R1 wb_valid", LW'(wb_valid), LW'(0));
    endtask

    task automatic t_chain();
        logic [LW-1:0] rl;
        logic [AW-1:0] ln;
        logic [63:0] s1, s2;
        ln = AW'(next_line); next_line++;
        rl = {64'h4444_0000_0000_0004, 64'h3333_0000_0000_0003,
              64'h2222_0000_0000_0002, 64'h1111_0000_0000_0001};
        s1 = wslot(rl, 1); s2 = wslot(rl, 2);
        @(negedge clk); drive(ln, 1, 4'd1, 1, 64'd5, rl); #1;
        chk("R2 chain A rsp", LW'(rsp_data), LW'(s1));
        @(negedge clk); drive(ln, 1, 4'd1, 1, 64'd7, rl); #1;
        chk("R6 chain stall", LW'(chain_stall), LW'(1));
        chk("R6 rsp suppressed", LW'(rsp_valid), LW'(0));
        @(negedge clk); #1;
        chk("R6 stall one cycle", LW'(chain_stall), LW'(0));
        chk("R7 forwarded old", LW'(rsp_data), LW'(s1 + 64'd5));
        chk("R5 chain A wb", LW'(wslot(wb_data, 1)), LW'(s1 + 64'd5));
        @(negedge clk); drive(ln, 2, 4'd3, 1, 64'hF0, rl); #1;
        chk("R6 chain stall C", LW'(chain_stall), LW'(1));
        @(negedge clk); #1;
        chk("R7 C old from array", LW'(rsp_data), LW'(s2));
        chk("R7 B wb", LW'(wslot(wb_data, 1)), LW'(s1 + 64'd12));
        @(negedge clk); idle();
        @(negedge clk); #1;
        chk("R7 cumulative be", LW'(wb_byte_en), LW'(exp_be(1, 1) | exp_be(2, 1)));
        chk("R7 cumulative w1", LW'(wslot(wb_data, 1)), LW'(s1 + 64'd12));
        chk("R7 cumulative w2", LW'(wslot(wb_data, 2)), LW'(s2 | 64'hF0));
    endtask

    task automatic t_diffline();
        logic [AW-1:0] l1, l2;
        logic [LW-1:0] rl;
        l1 = AW'(next_line); l2 = AW'(next_line + 1); next_line += 2;
        rl = {64'd40, 64'd30, 64'd20, 64'd10};
        @(negedge clk); drive(l1, 0, 4'd1, 1, 64'd1, rl); #1;
        @(negedge clk); drive(l2, 3, 4'd2, 1, 64'h3C, rl); #1;
        chk("R8 no stall", LW'(chain_stall), LW'(0));
        chk("R8 second rsp", LW'(rsp_valid), LW'(1));
        chk("R8 second old", LW'(rsp_data), LW'(64'd40));
        @(negedge clk); idle(); #1;
        chk("R8 first wb line", LW'(wb_line), LW'(l1));
        chk("R8 first wb word", LW'(wslot(wb_data, 0)), LW'(64'd11));
        @(negedge clk); #1;
        chk("R8 second wb valid", LW'(wb_valid), LW'(1));
        chk("R8 second wb line", LW'(wb_line), LW'(l2));
        chk("R8 fresh be", LW'(wb_byte_en), LW'(exp_be(3, 1)));
        chk("R8 second wb word", LW'(wslot(wb_data, 3)), LW'(64'd40 & 64'h3C));
    endtask

    task automatic t_nonamo();
        logic [AW-1:0] ln;
        ln = AW'(next_line); next_line++;
        @(negedge clk); drive(ln, 0, 4'd1, 1, 64'd1, '0);
        @(negedge clk); req_is_amo = 0; #1;
        chk("R9 no stall behind atomic", LW'(chain_stall), LW'(0));
        chk("R9 no rsp", LW'(rsp_valid), LW'(0));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk("R9 no busy", LW'(commit_busy), LW'(0));
            chk("R9 no stall", LW'(chain_stall), LW'(0));
            if (k > 0) chk("R9 no wb", LW'(wb_valid), LW'(0));
        end
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_single("swap", 0, 4'd0, 1, 64'h1111_2222_3333_4444, 64'hDEAD_BEEF_0000_0001);
        t_single("add",  1, 4'd1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
        t_single("and",  2, 4'd2, 1, 64'hF0F0_F0F0_F0F0_F0F0, 64'h0FF0_0FF0_0FF0_0FF0);
        t_single("or",   3, 4'd3, 1, 64'h1000_0000_0000_0001, 64'h0000_0000_8000_0000);
        t_single("xor",  0, 4'd4, 1, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_0000_FFFF_0000);
        t_single("min",  1, 4'd5, 1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd5);
        t_single("max",  2, 4'd6, 1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd5);
        t_single("minu", 3, 4'd7, 1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd5);
        t_single("maxu", 0, 4'd8, 1, 64'hFFFF_FFFF_FFFF_FFF0, 64'd5);
        t_single("w add ovf", 1, 4'd1, 0, 64'h1234_5678_7FFF_FFFF, 64'hABCD_0000_0000_0001);
        t_single("w min",     2, 4'd5, 0, 64'h0000_0001_FFFF_FFF0, 64'd5);
        t_single("w maxu",    3, 4'd8, 0, 64'h0000_0001_FFFF_FFF0, 64'd5);
        t_single("w swap",    0, 4'd0, 0, 64'h0000_0000_0000_0007, 64'h0000_0009_8000_0000);
        t_chain();
        t_diffline();
        t_nonamo();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule